// File: doc/BRIEF.md
# Trap Delegation Register Unit

This block stores the exception and interrupt delegation state for two privilege tiers of a processor core (machine level and hypervisor level) and decides, for every trap, which mode handles it: M, HS or VS. Software reaches the registers through a CSR access port addressed by a 12-bit CSR number. A trap query (cause code, interrupt flag, virtualised flag) is answered combinationally on the target-mode output, which the trap entry logic consumes.

Both exception delegation registers are 64 bits wide whatever the data width. With a 32-bit data path, each exception register is split in two. Its low-half address reaches bits 31:0 and a separate alias address reaches bits 63:32. With a 64-bit data path, the alias addresses do not exist and are reported as illegal. The interrupt delegation registers are as wide as the data path. Every register ignores writes to bits that the implementation mask leaves out, and those bits always read back as zero.

Delegation is two-tier. A trap is first delegated by the machine register bit whose index equals its cause. If that bit is set, the hypervisor register bit with the same index can pass it on to VS-mode, but only when the trap arises in a virtualised context.

Top module: `trap_deleg_csr`

## Requirements
- R1: After reset every delegation register reads zero, and every trap query answers M-mode.
- R2: With a 32-bit data path, address 0x302 reads and writes bits 31:0 of the 64-bit machine exception register, and 0x312 reads and writes bits 63:32. A write to one half leaves the other half unchanged. With a 64-bit data path, 0x302 reaches all 64 bits.
- R3: The hypervisor exception register follows the same rules: 0x602 holds the low half and 0x612 holds the high half.
- R4: The machine interrupt register at 0x303 and the hypervisor interrupt register at 0x603 are each one data word wide.
- R5: Each register bit outside its implementation mask ignores writes and reads back zero.
- R6: An access to an unmapped address raises csr_illegal in the same cycle. With a 64-bit data path, 0x312 and 0x612 count as unmapped. An illegal access reads zero and its write changes no register.
- R7: For an exception with cause c, the target is M (2'b11) when machine exception bit c is clear. When that bit is set, the target is HS (2'b01), unless the query is virtualised and hypervisor exception bit c is set, in which case it is VS (2'b10). This holds for causes 32 to 63 too.
- R8: Interrupt queries follow the R7 rule but use the interrupt registers. A cause at or above the data width is never delegated.
- R9: A hypervisor bit has no effect when the query is not virtualised, or when the matching machine bit is clear.
- R10: The target output is combinational from the query inputs. A register write changes it right after the clock edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_en | input | 1 | CSR access valid this cycle |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | CSR number |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data, combinational |
| csr_illegal | output | 1 | Access targets an address that does not exist |
| trap_cause | input | 6 | Cause code of the queried trap |
| trap_is_irq | input | 1 | Query is an interrupt |
| trap_virt | input | 1 | Trap arises in a virtualised context |
| trap_target | output | 2 | 2'b11 M, 2'b01 HS, 2'b10 VS |

## Verification
The bench writes all ones to one half of an exception register and then reads both halves. A design that merged the halves, or cleared the other half on a write, would return the wrong word at the alias address. Queries on causes above 31 catch a selector that only looks at the low word. Queries where only the hypervisor bit is set, or where the query is not virtualised, catch a design that delegates to VS-mode without both conditions. A second instance with a 64-bit data path accesses the alias addresses and then reads the real registers. This exposes a design that does not flag those addresses as illegal or that lets their writes land in a register.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

  typedef enum logic [1:0] {
    TGT_HS = 2'b01,
    TGT_VS = 2'b10,
    TGT_M  = 2'b11
  } tgt_e;

  localparam logic [11:0] ADDR_MEXC_LO = 12'h302;
  localparam logic [11:0] ADDR_MIRQ    = 12'h303;
  localparam logic [11:0] ADDR_MEXC_HI = 12'h312;
  localparam logic [11:0] ADDR_HEXC_LO = 12'h602;
  localparam logic [11:0] ADDR_HIRQ    = 12'h603;
  localparam logic [11:0] ADDR_HEXC_HI = 12'h612;

  localparam int SEL_MEXC_LO = 0;
  localparam int SEL_MEXC_HI = 1;
  localparam int SEL_MIRQ    = 2;
  localparam int SEL_HEXC_LO = 3;
  localparam int SEL_HEXC_HI = 4;
  localparam int SEL_HIRQ    = 5;
  localparam int NSEL        = 6;

  localparam int EXC_W   = 64;
  localparam int CAUSE_W = 6;

endpackage

// File: rtl/tdl_decode.sv
module tdl_decode
  import tdl_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_en,
  input  logic [11:0]     csr_addr,
  output logic [NSEL-1:0] sel,
  output logic            illegal
);

  localparam bit HAS_HI = (XLEN == 32);

  always_comb begin
    sel = '0;
    case (csr_addr)
      ADDR_MEXC_LO: sel[SEL_MEXC_LO] = 1'b1;
      ADDR_MEXC_HI: sel[SEL_MEXC_HI] = HAS_HI;
      ADDR_MIRQ:    sel[SEL_MIRQ]    = 1'b1;
      ADDR_HEXC_LO: sel[SEL_HEXC_LO] = 1'b1;
      ADDR_HEXC_HI: sel[SEL_HEXC_HI] = HAS_HI;
      ADDR_HIRQ:    sel[SEL_HIRQ]    = 1'b1;
      default:      sel = '0;
    endcase
    if (!csr_en) sel = '0;
    illegal = csr_en && (sel == '0);
  end

  // R6
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_en |-> ($countones({sel, illegal}) == 1));

endmodule

// File: rtl/tdl_warl_reg.sv
module tdl_warl_reg #(
  parameter int                    SEG  = 32,
  parameter int                    NSEG = 2,
  parameter logic [SEG*NSEG-1:0]   MASK = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSEG-1:0]      seg_we,
  input  logic [SEG-1:0]       wdata,
  output logic [SEG*NSEG-1:0]  q
);

  localparam int W = SEG * NSEG;

  logic [W-1:0] q_next;
  logic         q_en;

  always_comb begin
    q_next = q;
    for (int s = 0; s < NSEG; s++) begin
      if (seg_we[s]) q_next[s*SEG +: SEG] = wdata & MASK[s*SEG +: SEG];
    end
    q_en = |seg_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_next;
  end

  for (genvar g = 0; g < NSEG; g++) begin : g_seg_chk
    // R2
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !seg_we[g] |=> $stable(q[g*SEG +: SEG]));
    // R5
    seg_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seg_we[g] |=> ((q[g*SEG +: SEG] & ~MASK[g*SEG +: SEG]) == '0));
  end

endmodule

// File: rtl/tdl_target.sv
module tdl_target
  import tdl_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [EXC_W-1:0]   m_exc,
  input  logic [EXC_W-1:0]   h_exc,
  input  logic [XLEN-1:0]    m_irq,
  input  logic [XLEN-1:0]    h_irq,
  input  logic [CAUSE_W-1:0] cause,
  input  logic               is_irq,
  input  logic               virt,
  output logic [1:0]         target
);

  logic [EXC_W-1:0] m_irq_w;
  logic [EXC_W-1:0] h_irq_w;
  logic             m_hit;
  logic             h_hit;

  always_comb begin
    m_irq_w = EXC_W'(m_irq);
    h_irq_w = EXC_W'(h_irq);
    if (is_irq) begin
      m_hit = m_irq_w[cause];
      h_hit = h_irq_w[cause];
    end else begin
      m_hit = m_exc[cause];
      h_hit = h_exc[cause];
    end
    if (!m_hit)             target = TGT_M;
    else if (virt && h_hit) target = TGT_VS;
    else                    target = TGT_HS;
  end

  // R9
  always_comb begin
    if (target == TGT_VS) vs_needs_virt_chk: assert (virt);
  end

endmodule

// File: rtl/trap_deleg_csr.sv
module trap_deleg_csr
  import tdl_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter logic [63:0] M_EXC_MASK = 64'h0000_00FF_0000_F7FF,
  parameter logic [63:0] H_EXC_MASK = 64'h0000_00FF_0000_B1FF,
  parameter logic [63:0] M_IRQ_MASK = 64'h0000_0000_0000_1666,
  parameter logic [63:0] H_IRQ_MASK = 64'h0000_0000_0000_0444
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_en,
  input  logic               csr_we,
  input  logic [11:0]        csr_addr,
  input  logic [XLEN-1:0]    csr_wdata,
  output logic [XLEN-1:0]    csr_rdata,
  output logic               csr_illegal,
  input  logic [5:0]         trap_cause,
  input  logic               trap_is_irq,
  input  logic               trap_virt,
  output logic [1:0]         trap_target
);

  localparam int EXC_NSEG = EXC_W / XLEN;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_int = rst_sync[1];

  logic [NSEL-1:0]     sel;
  logic                wr;
  logic [EXC_NSEG-1:0] m_exc_we;
  logic [EXC_NSEG-1:0] h_exc_we;
  logic                m_irq_we;
  logic                h_irq_we;
  logic [EXC_W-1:0]    m_exc;
  logic [EXC_W-1:0]    h_exc;
  logic [XLEN-1:0]     m_irq;
  logic [XLEN-1:0]     h_irq;

  tdl_decode #(.XLEN(XLEN)) u_decode (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .csr_en   (csr_en),
    .csr_addr (csr_addr),
    .sel      (sel),
    .illegal  (csr_illegal)
  );

  assign wr = csr_we && !csr_illegal;

  if (XLEN == 32) begin : g_split
    assign m_exc_we = {wr && sel[SEL_MEXC_HI], wr && sel[SEL_MEXC_LO]};
    assign h_exc_we = {wr && sel[SEL_HEXC_HI], wr && sel[SEL_HEXC_LO]};
  end else begin : g_full
    assign m_exc_we = wr && sel[SEL_MEXC_LO];
    assign h_exc_we = wr && sel[SEL_HEXC_LO];
  end

  assign m_irq_we = wr && sel[SEL_MIRQ];
  assign h_irq_we = wr && sel[SEL_HIRQ];

  tdl_warl_reg #(.SEG(XLEN), .NSEG(EXC_NSEG), .MASK(M_EXC_MASK)) u_m_exc (
    .clk (clk), .rst_n (rst_n_int), .seg_we (m_exc_we), .wdata (csr_wdata), .q (m_exc)
  );

  tdl_warl_reg #(.SEG(XLEN), .NSEG(EXC_NSEG), .MASK(H_EXC_MASK)) u_h_exc (
    .clk (clk), .rst_n (rst_n_int), .seg_we (h_exc_we), .wdata (csr_wdata), .q (h_exc)
  );

  tdl_warl_reg #(.SEG(XLEN), .NSEG(1), .MASK(M_IRQ_MASK[XLEN-1:0])) u_m_irq (
    .clk (clk), .rst_n (rst_n_int), .seg_we (m_irq_we), .wdata (csr_wdata), .q (m_irq)
  );

  tdl_warl_reg #(.SEG(XLEN), .NSEG(1), .MASK(H_IRQ_MASK[XLEN-1:0])) u_h_irq (
    .clk (clk), .rst_n (rst_n_int), .seg_we (h_irq_we), .wdata (csr_wdata), .q (h_irq)
  );

  always_comb begin
    csr_rdata = '0;
    if (sel[SEL_MEXC_LO]) csr_rdata = m_exc[XLEN-1:0];
    if (sel[SEL_MEXC_HI]) csr_rdata = m_exc[EXC_W-1 -: XLEN];
    if (sel[SEL_MIRQ])    csr_rdata = m_irq;
    if (sel[SEL_HEXC_LO]) csr_rdata = h_exc[XLEN-1:0];
    if (sel[SEL_HEXC_HI]) csr_rdata = h_exc[EXC_W-1 -: XLEN];
    if (sel[SEL_HIRQ])    csr_rdata = h_irq;
  end

  tdl_target #(.XLEN(XLEN)) u_target (
    .m_exc  (m_exc),
    .h_exc  (h_exc),
    .m_irq  (m_irq),
    .h_irq  (h_irq),
    .cause  (trap_cause),
    .is_irq (trap_is_irq),
    .virt   (trap_virt),
    .target (trap_target)
  );

  // R6
  illegal_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    csr_illegal |-> (csr_rdata == '0));

  // R6
  illegal_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    csr_illegal |=> ($stable(m_exc) && $stable(h_exc) && $stable(m_irq) && $stable(h_irq)));

  // R6
  idle_legal_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !csr_en |-> !csr_illegal);

endmodule

// File: tb/test_trap_deleg_csr.sv
module test_trap_deleg_csr;

  localparam logic [63:0] MEM = 64'h0000_00FF_0000_F7FF;
  localparam logic [63:0] HEM = 64'h0000_00FF_0000_B1FF;
  localparam logic [63:0] MIM = 64'h0000_0000_0000_1666;
  localparam logic [63:0] HIM = 64'h0000_0000_0000_0444;
  localparam logic [1:0]  T_M  = 2'b11;
  localparam logic [1:0]  T_HS = 2'b01;
  localparam logic [1:0]  T_VS = 2'b10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // 32-bit instance
  logic        en, we, irq, virt;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;
  logic        ill;
  logic [5:0]  cause;
  logic [1:0]  tgt;

  // 64-bit instance
  logic        en6, we6;
  logic [11:0] addr6;
  logic [63:0] wdata6, rdata6;
  logic        ill6;
  logic [1:0]  tgt6;

  trap_deleg_csr #(.XLEN(32), .M_EXC_MASK(MEM), .H_EXC_MASK(HEM),
                   .M_IRQ_MASK(MIM), .H_IRQ_MASK(HIM)) i_trap_deleg_csr (
    .clk (clk), .rst_n (rst_n), .csr_en (en), .csr_we (we), .csr_addr (addr),
    .csr_wdata (wdata), .csr_rdata (rdata), .csr_illegal (ill),
    .trap_cause (cause), .trap_is_irq (irq), .trap_virt (virt), .trap_target (tgt)
  );

  trap_deleg_csr #(.XLEN(64), .M_EXC_MASK(MEM), .H_EXC_MASK(HEM),
                   .M_IRQ_MASK(MIM), .H_IRQ_MASK(HIM)) i_trap_deleg_csr_w64 (
    .clk (clk), .rst_n (rst_n), .csr_en (en6), .csr_we (we6), .csr_addr (addr6),
    .csr_wdata (wdata6), .csr_rdata (rdata6), .csr_illegal (ill6),
    .trap_cause (cause), .trap_is_irq (irq), .trap_virt (virt), .trap_target (tgt6)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr32(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    en = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    en = 1'b0; we = 1'b0;
  endtask

  task automatic rd32(input logic [11:0] a, output logic [31:0] d, output logic i);
    @(negedge clk);
    en = 1'b1; we = 1'b0; addr = a;
    #1;
    d = rdata; i = ill;
    en = 1'b0;
  endtask

  task automatic wr64(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    en6 = 1'b1; we6 = 1'b1; addr6 = a; wdata6 = d;
    @(negedge clk);
    en6 = 1'b0; we6 = 1'b0;
  endtask

  task automatic rd64(input logic [11:0] a, output logic [63:0] d, output logic i);
    @(negedge clk);
    en6 = 1'b1; we6 = 1'b0; addr6 = a;
    #1;
    d = rdata6; i = ill6;
    en6 = 1'b0;
  endtask

  task automatic query(input logic [5:0] c, input logic is_i, input logic v);
    cause = c; irq = is_i; virt = v;
    #1;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic i;
    rd32(12'h302, d, i); check("R1 mexc lo reset", d, 0);
    rd32(12'h312, d, i); check("R1 mexc hi reset", d, 0);
    rd32(12'h303, d, i); check("R1 mirq reset", d, 0);
    rd32(12'h602, d, i); check("R1 hexc lo reset", d, 0);
    rd32(12'h612, d, i); check("R1 hexc hi reset", d, 0);
    rd32(12'h603, d, i); check("R1 hirq reset", d, 0);
    query(6'd8, 1'b0, 1'b1); check("R1 target after reset", tgt, T_M);
    query(6'd5, 1'b1, 1'b0); check("R1 irq target after reset", tgt, T_M);
  endtask

  task automatic t_mexc_halves;
    logic [31:0] d; logic i;
    wr32(12'h302, 32'hFFFF_FFFF);
    rd32(12'h302, d, i); check("R2 mexc lo write", d, MEM[31:0]);
    check("R2 legal access", i, 0);
    rd32(12'h312, d, i); check("R2 hi untouched by lo write", d, 0);
    wr32(12'h312, 32'hFFFF_FFFF);
    rd32(12'h312, d, i); check("R2 mexc hi write", d, MEM[63:32]);
    rd32(12'h302, d, i); check("R2 lo untouched by hi write", d, MEM[31:0]);
    wr32(12'h302, 32'h0);
    rd32(12'h312, d, i); check("R2 hi kept after lo clear", d, MEM[63:32]);
    wr32(12'h312, 32'h0);
  endtask

  task automatic t_hexc_halves;
    logic [31:0] d; logic i;
    wr32(12'h612, 32'hFFFF_FFFF);
    rd32(12'h612, d, i); check("R3 hexc hi write", d, HEM[63:32]);
    rd32(12'h602, d, i); check("R3 lo untouched by hi write", d, 0);
    wr32(12'h602, 32'hFFFF_FFFF);
    rd32(12'h602, d, i); check("R3 hexc lo write", d, HEM[31:0]);
    wr32(12'h612, 32'h0);
    rd32(12'h602, d, i); check("R3 lo kept after hi clear", d, HEM[31:0]);
    wr32(12'h602, 32'h0);
  endtask

  task automatic t_irq_mask;
    logic [31:0] d; logic i;
    wr32(12'h303, 32'hFFFF_FFFF);
    rd32(12'h303, d, i); check("R4 R5 mirq masked", d, MIM[31:0]);
    wr32(12'h603, 32'hFFFF_FFFF);
    rd32(12'h603, d, i); check("R4 R5 hirq masked", d, HIM[31:0]);
    wr32(12'h302, 32'h0000_0800);
    rd32(12'h302, d, i); check("R5 unimplemented bit reads zero", d, 0);
    wr32(12'h303, 32'h0); wr32(12'h603, 32'h0);
  endtask

  task automatic t_target_exc;
    wr32(12'h302, 32'h0000_0104);
    wr32(12'h602, 32'h0000_0108);
    wr32(12'h312, 32'h0000_0001);
    query(6'd8, 1'b0, 1'b1); check("R7 both bits virt -> VS", tgt, T_VS);
    query(6'd8, 1'b0, 1'b0); check("R9 not virtualised -> HS", tgt, T_HS);
    query(6'd2, 1'b0, 1'b1); check("R7 machine only -> HS", tgt, T_HS);
    query(6'd3, 1'b0, 1'b1); check("R9 hyp bit alone ignored -> M", tgt, T_M);
    query(6'd32, 1'b0, 1'b1); check("R7 high cause delegated -> HS", tgt, T_HS);
    query(6'd33, 1'b0, 1'b0); check("R7 high cause clear -> M", tgt, T_M);
    query(6'd8, 1'b1, 1'b1); check("R8 irq ignores exc regs -> M", tgt, T_M);
  endtask

  task automatic t_target_irq;
    wr32(12'h303, 32'h0000_0024);
    wr32(12'h603, 32'h0000_0004);
    query(6'd2, 1'b1, 1'b1); check("R8 irq both bits virt -> VS", tgt, T_VS);
    query(6'd5, 1'b1, 1'b1); check("R8 irq machine only -> HS", tgt, T_HS);
    query(6'd2, 1'b1, 1'b0); check("R9 irq not virtualised -> HS", tgt, T_HS);
    query(6'd40, 1'b1, 1'b1); check("R8 irq cause above width -> M", tgt, T_M);
  endtask

  task automatic t_comb;
    // machine bit 12 currently clear
    query(6'd12, 1'b0, 1'b0); check("R10 before write -> M", tgt, T_M);
    @(negedge clk);
    en = 1'b1; we = 1'b1; addr = 12'h302; wdata = 32'h0000_1104;
    #2; check("R10 unchanged before edge", tgt, T_M);
    @(posedge clk); #1;
    check("R10 changes right after edge", tgt, T_HS);
    en = 1'b0; we = 1'b0;
    query(6'd13, 1'b0, 1'b0); check("R10 follows query at once", tgt, T_M);
  endtask

  task automatic t_illegal;
    logic [31:0] d; logic i;
    logic [63:0] d6; logic i6;
    rd32(12'h305, d, i); check("R6 unmapped flagged", i, 1);
    check("R6 unmapped reads zero", d, 0);
    wr32(12'h305, 32'hFFFF_FFFF);
    rd32(12'h302, d, i); check("R6 unmapped write no effect", d, 32'h0000_1104);
    rd64(12'h312, d6, i6); check("R6 w64 alias 0x312 illegal", i6, 1);
    check("R6 w64 alias reads zero", d6, 0);
    rd64(12'h612, d6, i6); check("R6 w64 alias 0x612 illegal", i6, 1);
    wr64(12'h312, 64'hFFFF_FFFF_FFFF_FFFF);
    rd64(12'h302, d6, i6); check("R6 w64 alias write no effect", d6, 0);
    wr64(12'h302, 64'hFFFF_FFFF_FFFF_FFFF);
    rd64(12'h302, d6, i6); check("R2 w64 full width", d6, MEM);
    check("R2 w64 legal", i6, 0);
    query(6'd39, 1'b0, 1'b0); check("R7 w64 high cause -> HS", tgt6, T_HS);
  endtask

  initial begin
    en = 0; we = 0; addr = '0; wdata = '0;
    en6 = 0; we6 = 0; addr6 = '0; wdata6 = '0;
    cause = '0; irq = 0; virt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_mexc_halves();
    t_hexc_halves();
    t_irq_mask();
    t_target_exc();
    t_target_irq();
    t_comb();
    t_illegal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule